// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block holds a small set of recent virtual-to-physical page translations for 8 KB pages. A requester presents a virtual address, an address-space identifier and an access type (read or write). Every stored entry is compared against the request at the same time, and the answer is produced combinationally in the same cycle. A hit returns the physical address: the stored frame number with the untranslated 13-bit page offset appended. A matching entry that forbids the access type returns a protection fault instead. No match is reported as a miss.

Each entry carries an address-space tag, so translations from different processes can sit in the table together and a context switch needs no flush. After a miss, an external page-table walker installs the translation through the fill port. The victim is an invalid entry when one exists. Otherwise a free-running pseudo-random generator picks the victim, and it is steered away from the entry that hit most recently. Two flush controls are provided: one empties the whole table, the other drops only the entries of a single address space. The entry count is a parameter; 8 suits an instruction-side table and 32 a data-side one.

Each request is classified into one of four response kinds. IDLE means no request. MISS means no valid entry matches both tag and address space. HIT means a match whose rights allow the access. FAULT means a match whose rights forbid it. The kind is recomputed from scratch every cycle, so there are no transitions to describe.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss (rsp_hit=0, rsp_fault=0).
- R2: A lookup that matches a valid, permitted entry raises rsp_hit in the same cycle. rsp_pa is then {frame number, lk_va[12:0]}, and the virtual page number is lk_va[42:13].
- R3: A match requires both the virtual page number and the address-space identifier to be equal; the same page under another identifier misses.
- R4: Access type lk_write=0 needs the entry's read right and lk_write=1 needs its write right. A matching entry lacking the right gives rsp_fault=1 and rsp_hit=0, and both are never high together.
- R5: A fill writes the lowest-index invalid entry whenever any entry is invalid, leaving all valid entries untouched.
- R6: With the table full, the fill index is L mod ENTRIES. L is a 16-bit shift register: reset value 0xACE1, and on every clock after reset it shifts left with new bit 0 = b15^b13^b12^b10. If that index equals the most recently hit entry, the index (L mod ENTRIES)+1, wrapping to 0, is used instead.
- R7: The most recently hit entry (index 0 after reset) is never the victim of a fill into a full table.
- R8: flush_all invalidates every entry in one cycle.
- R9: flush_asid_en invalidates exactly the entries whose identifier equals flush_asid and keeps the others.
- R10: When a fill and a lookup occur in the same cycle, the lookup sees the table as it was before the fill.
- R11: A fill in the same cycle as either flush input is dropped.
- R12: With lk_valid low, rsp_hit and rsp_fault stay low whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | VA_W (43) | Virtual address to translate |
| lk_asid | input | ASID_W (8) | Address-space identifier of the lookup |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_fault | output | 1 | Match found but access right missing |
| rsp_pa | output | PFN_W+OFF_W (34) | Physical address, meaningful with rsp_hit |
| fill_en | input | 1 | Install a new entry |
| fill_vpn | input | VA_W-OFF_W (30) | Virtual page number to install |
| fill_asid | input | ASID_W (8) | Identifier of the new entry |
| fill_pfn | input | PFN_W (21) | Physical frame number of the new entry |
| fill_rd | input | 1 | Read right of the new entry |
| fill_wr | input | 1 | Write right of the new entry |
| flush_all | input | 1 | Invalidate the whole table |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W (8) | Identifier to invalidate |

## Verification
The assertions check, on every cycle, that hit and fault exclude each other and stay low without a request, and that a hit keeps the page offset. They also check that a full flush empties the table, that a fill into a non-full table adds exactly one valid entry, and that the chosen victim in a full table differs from the most recently hit entry. Only the bench scenarios can show which entry is actually evicted, since that depends on the generator sequence, the recency tracking and the per-identifier flush. The same holds for the pre-fill view of a same-cycle lookup. The bench shows these by running a behavioural table model next to the design.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Classification of the current lookup
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_MISS  = 2'd1,
        RSP_HIT   = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_kind_e;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_SEED = 16'hACE1;

    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/tlb_rnd.sv
module tlb_rnd
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rnd <= RND_SEED;
        else        rnd <= rnd_step(rnd);
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 8,
    parameter int VPN_W  = 30,
    parameter int ASID_W = 8
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][VPN_W-1:0]  tags,
    input  logic [N-1:0][ASID_W-1:0] asids,
    input  logic [VPN_W-1:0]         vpn,
    input  logic [ASID_W-1:0]        asid,
    output logic [N-1:0]             match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == vpn) && (asids[g] == asid);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [RND_W-1:0] rnd,
    input  logic [IDX_W-1:0] mru,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] free_idx;
    logic             have_free;
    logic [IDX_W-1:0] rnd_idx;

    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!have_free && !valid[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
        end
    end

    always_comb begin
        rnd_idx = IDX_W'(32'(rnd) % N);
        if (rnd_idx == mru) rnd_idx = (rnd_idx == LAST) ? '0 : rnd_idx + 1'b1;
    end

    assign victim = have_free ? free_idx : rnd_idx;
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 43,
    parameter int OFF_W   = 13,
    parameter int PFN_W   = 21,
    parameter int ASID_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [VA_W-1:0]         lk_va,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic                    lk_write,
    output logic                    rsp_hit,
    output logic                    rsp_fault,
    output logic [PFN_W+OFF_W-1:0]  rsp_pa,
    input  logic                    fill_en,
    input  logic [VA_W-OFF_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic [PFN_W-1:0]        fill_pfn,
    input  logic                    fill_rd,
    input  logic                    fill_wr,
    input  logic                    flush_all,
    input  logic                    flush_asid_en,
    input  logic [ASID_W-1:0]       flush_asid
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Table storage
    logic [ENTRIES-1:0]             valid_q, rd_q, wr_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
    logic [IDX_W-1:0]               mru_q;

    logic [ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic               any_match;
    logic               permitted;
    logic [RND_W-1:0]   rnd;
    logic [IDX_W-1:0]   victim_idx;
    rsp_kind_e          kind;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .valid (valid_q),
        .tags  (tag_q),
        .asids (asid_q),
        .vpn   (lk_va[VA_W-1:OFF_W]),
        .asid  (lk_asid),
        .match (match_vec)
    );

    tlb_rnd u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid  (valid_q),
        .rnd    (rnd),
        .mru    (mru_q),
        .victim (victim_idx)
    );

    // Encode the matching entry
    always_comb begin
        hit_idx   = '0;
        any_match = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx   = IDX_W'(i);
                any_match = 1'b1;
            end
        end
    end

    assign permitted = lk_write ? wr_q[hit_idx] : rd_q[hit_idx];

    // Response classification
    always_comb begin
        if (!lk_valid)      kind = RSP_IDLE;
        else if (!any_match) kind = RSP_MISS;
        else if (permitted) kind = RSP_HIT;
        else                kind = RSP_FAULT;
    end

    // Response outputs
    always_comb begin
        rsp_hit   = 1'b0;
        rsp_fault = 1'b0;
        rsp_pa    = '0;
        unique case (kind)
            RSP_IDLE, RSP_MISS: ;
            RSP_HIT: begin
                rsp_hit = 1'b1;
                rsp_pa  = {pfn_q[hit_idx], lk_va[OFF_W-1:0]};
            end
            RSP_FAULT: rsp_fault = 1'b1;
        endcase
    end

    // Recency tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               mru_q <= '0;
        else if (kind == RSP_HIT) mru_q <= hit_idx;
    end

    // Valid bits: flush has priority, a fill alongside a flush is dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < ENTRIES; i++)
                if (asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
        end else if (fill_en) begin
            valid_q[victim_idx] <= 1'b1;
        end
    end

    // Entry payload
    always_ff @(posedge clk) begin
        if (fill_en && !flush_all && !flush_asid_en) begin
            rd_q[victim_idx]   <= fill_rd;
            wr_q[victim_idx]   <= fill_wr;
            tag_q[victim_idx]  <= fill_vpn;
            asid_q[victim_idx] <= fill_asid;
            pfn_q[victim_idx]  <= fill_pfn;
        end
    end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N     = 8,
    parameter int VA_W  = 43,
    parameter int OFF_W = 13,
    parameter int PA_W  = 34,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_va,
    input logic             rsp_hit,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             fill_en,
    input logic             flush_all,
    input logic             flush_asid_en,
    input logic [N-1:0]     valid_q,
    input logic [IDX_W-1:0] mru_q,
    input logic [IDX_W-1:0] victim_idx
);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!rsp_hit && !rsp_fault));

    // R4
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    // R7
    mru_spared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_asid_en && (&valid_q)) |-> (victim_idx != mru_q));

    // R5
    free_slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_asid_en && !(&valid_q))
        |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

    // R11
    flush_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_asid_en && !flush_all) |=> ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

bind xlat_tlb tlb_chk #(
    .N(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PFN_W + OFF_W)
) u_tlb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_va         (lk_va),
    .rsp_hit       (rsp_hit),
    .rsp_fault     (rsp_fault),
    .rsp_pa        (rsp_pa),
    .fill_en       (fill_en),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .valid_q       (valid_q),
    .mru_q         (mru_q),
    .victim_idx    (victim_idx)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [42:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        rsp_hit, rsp_fault;
    logic [33:0] rsp_pa;
    logic        fill_en = 1'b0;
    logic [29:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [20:0] fill_pfn = '0;
    logic        fill_rd = 1'b0, fill_wr = 1'b0;
    logic        flush_all = 1'b0, flush_asid_en = 1'b0;
    logic [7:0]  flush_asid = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    xlat_tlb #(.ENTRIES(N)) dut_i (.*);

    // Behavioural model of the table
    bit          m_v[N], m_rd[N], m_wr[N];
    logic [29:0] m_tag[N];
    logic [7:0]  m_asid[N];
    logic [20:0] m_pfn[N];
    int          m_mru;
    int          m_lf;

    task automatic chk(bit ok, string rq, longint unsigned act, longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int m_find(logic [29:0] vpn, logic [7:0] asid);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_tag[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        int r;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        r = m_lf % N;
        if (r == m_mru) r = (r + 1) % N;
        return r;
    endfunction

    // One clock: compare outputs against the model, then advance the model
    task automatic cyc();
        int e, v;
        bit ehit, eflt;
        logic [33:0] epa;
        string rq;
        #1;
        e = m_find(lk_va[42:13], lk_asid);
        ehit = 0; eflt = 0; epa = '0;
        if (lk_valid && e >= 0) begin
            if (lk_write ? m_wr[e] : m_rd[e]) begin
                ehit = 1;
                epa  = {m_pfn[e], lk_va[12:0]};
            end else eflt = 1;
        end
        rq = !lk_valid ? "R12" : (e < 0 ? "R3" : (eflt ? "R4" : "R2"));
        chk({rsp_hit, rsp_fault} === {ehit, eflt}, rq, {rsp_hit, rsp_fault}, {ehit, eflt});
        if (ehit) chk(rsp_pa === epa, "R2 address", rsp_pa, epa);
        v = m_victim();
        @(posedge clk);
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == flush_asid) m_v[i] = 0;
        end else if (fill_en) begin
            m_v[v] = 1; m_rd[v] = fill_rd; m_wr[v] = fill_wr;
            m_tag[v] = fill_vpn; m_asid[v] = fill_asid; m_pfn[v] = fill_pfn;
        end
        if (ehit) m_mru = e;
        m_lf = ((m_lf << 1) | (((m_lf >> 15) ^ (m_lf >> 13) ^ (m_lf >> 12) ^ (m_lf >> 10)) & 1)) & 16'hFFFF;
        @(negedge clk);
    endtask

    task automatic idle_in();
        lk_valid = 0; fill_en = 0; flush_all = 0; flush_asid_en = 0; lk_write = 0;
    endtask

    task automatic set_lk(logic [29:0] vpn, logic [7:0] asid, bit wr);
        lk_valid = 1; lk_va = {vpn, 13'h0A5}; lk_asid = asid; lk_write = wr;
    endtask

    task automatic set_fill(logic [29:0] vpn, logic [7:0] asid, logic [20:0] pfn, bit rd, bit wr);
        fill_en = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_rd = rd; fill_wr = wr;
    endtask

    // Read lookup with an explicit hit expectation
    task automatic expect_hit(logic [29:0] vpn, logic [7:0] asid, bit exp, string rq);
        idle_in();
        set_lk(vpn, asid, 0);
        #1 chk(rsp_hit === exp, rq, rsp_hit, exp);
        cyc();
    endtask

    task automatic do_fill(logic [29:0] vpn, logic [7:0] asid, bit rd, bit wr);
        idle_in();
        set_fill(vpn, asid, 21'(vpn * 37 + 5), rd, wr);
        cyc();
        idle_in();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_mru = 0; m_lf = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1;

        expect_hit(30'd5, 8'd1, 0, "R1 empty after reset");

        // Fill all entries; entry 5 is write-only, odd entries writable
        for (int i = 0; i < N; i++) do_fill(30'(100 + i), 8'd1, i != 5, i % 2 == 1);
        for (int i = 0; i < N; i++) begin
            idle_in(); set_lk(30'(100 + i), 8'd1, 0); cyc();
            idle_in(); set_lk(30'(100 + i), 8'd1, 1); cyc();
        end
        expect_hit(30'd100, 8'd1, 1, "R2 hit");
        idle_in(); set_lk(30'd105, 8'd1, 0);
        #1 chk(rsp_fault === 1'b1, "R4 read without right", rsp_fault, 1);
        cyc();
        expect_hit(30'd100, 8'd2, 0, "R3 other identifier");

        // Fill and lookup of the same key together
        idle_in(); set_lk(30'd200, 8'd1, 0); set_fill(30'd200, 8'd1, 21'h1ABCD, 1, 1);
        #1 chk(rsp_hit === 1'b0, "R10 pre-fill view", rsp_hit, 0);
        cyc();
        expect_hit(30'd200, 8'd1, 1, "R10 visible after fill");

        // Keep hitting one entry while filling a full table
        for (int j = 0; j < 16; j++) begin
            idle_in(); set_lk(30'd200, 8'd1, 0); set_fill(30'(300 + j), 8'd1, 21'(j), 1, 0);
            #1 chk(rsp_hit === 1'b1, "R7 recent entry kept", rsp_hit, 1);
            cyc();
        end
        for (int j = 0; j < 16; j++)
            expect_hit(30'(300 + j), 8'd1, m_find(30'(300 + j), 8'd1) >= 0, "R6 random victim");
        expect_hit(30'd200, 8'd1, 1, "R7 recent entry kept");

        // Per-identifier flush
        do_fill(30'd400, 8'd3, 1, 1);
        do_fill(30'd401, 8'd3, 1, 0);
        idle_in(); flush_asid_en = 1; flush_asid = 8'd1; cyc(); idle_in();
        expect_hit(30'd400, 8'd3, 1, "R9 other identifier kept");
        expect_hit(30'd401, 8'd3, 1, "R9 other identifier kept");
        expect_hit(30'd200, 8'd1, 0, "R9 identifier flushed");

        // Free entries are used before any valid one
        for (int i = 0; i < 6; i++) do_fill(30'(500 + i), 8'd4, 1, 1);
        expect_hit(30'd400, 8'd3, 1, "R5 free entries first");
        expect_hit(30'd401, 8'd3, 1, "R5 free entries first");
        expect_hit(30'd505, 8'd4, 1, "R5 new entry present");

        // Fill together with a flush is dropped
        idle_in(); set_fill(30'd600, 8'd4, 21'h77, 1, 1); flush_asid_en = 1; flush_asid = 8'd7;
        cyc(); idle_in();
        expect_hit(30'd600, 8'd4, 0, "R11 fill dropped");
        expect_hit(30'd400, 8'd3, 1, "R11 unrelated flush keeps entry");

        // Full flush
        idle_in(); flush_all = 1; cyc(); idle_in();
        expect_hit(30'd400, 8'd3, 0, "R8 flushed");
        expect_hit(30'd500, 8'd4, 0, "R8 flushed");

        // No request, no response
        do_fill(30'd700, 8'd2, 1, 1);
        idle_in(); lk_va = {30'd700, 13'h1}; lk_asid = 8'd2;
        #1 chk(rsp_hit === 1'b0, "R12 idle", rsp_hit, 0);
        cyc();

        // Mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [29:0] fv;
            logic [7:0]  fa;
            idle_in();
            lk_valid = ($urandom_range(0, 3) != 0);
            lk_va    = {30'($urandom_range(0, 15)), 13'($urandom)};
            lk_asid  = 8'($urandom_range(0, 2));
            lk_write = 1'($urandom);
            fv = 30'($urandom_range(0, 15));
            fa = 8'($urandom_range(0, 2));
            if ($urandom_range(0, 9) < 3 && m_find(fv, fa) < 0)
                set_fill(fv, fa, 21'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 99) < 2) begin
                flush_asid_en = 1; flush_asid = 8'($urandom_range(0, 2));
            end
            if ($urandom_range(0, 99) < 1) flush_all = 1;
            cyc();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule